// File: doc/BRIEF.md
# Address-Space TLB Invalidate Access Judge

This block decides what happens when software issues the inner-shareable TLB invalidate that works by address-space identifier. Each request strobe samples the current privilege level and the hypervisor's state and trap controls. It samples whether the kernel level can run 32-bit code. It also samples the controls that choose the XS attribute filter. From these it registers a single decision. The decision is one of four: undefined instruction, a trap to the hypervisor through its 64-bit entry path, a trap to the hypervisor through its 32-bit entry path, or execute.

A trap decision carries a syndrome code and the index of the trap condition that won. An execute decision carries the translation regime to invalidate, whether the current virtual-machine identifier or none is used, and the attribute filter. The exception entry logic and the TLB walker that acts on the result are not part of the block.

Top module: `tlbi_access_judge`

## Requirements
- R1: A request at privilege level 0 (`lvl_in` = 0) yields kind UNDEF (`res_kind` = 0) and cause 0.
- R2: When `k32_ok` is 0, a request at any privilege level yields kind UNDEF (`res_kind` = 0), syndrome 0 and cause 0.
- R3: At level 1 with the hypervisor enabled, six trap conditions are tried in this order, and the first true one wins: cause 1 = `grp_trap64` while `hyp_32` is 0 (kind TRAP64 = 1); cause 2 = `grp_trap32` while `hyp_32` is 1 (kind TRAP32 = 2); cause 3 = `tlb_trap64` while `hyp_32` is 0 (TRAP64); cause 4 = `tlbis_trap64` while `hyp_32` is 0 (TRAP64); cause 5 = `tlb_trap32` while `hyp_32` is 1 (TRAP32); cause 6 = `tlbis_trap32` while `hyp_32` is 1 (TRAP32).
- R4: Every trap decision reports syndrome 0x03 on `res_synd`. Every non-trap decision reports syndrome 0.
- R5: A request at level 1 with no trap condition true, or with `hyp_en` = 0 whatever the trap bits, yields kind EXEC (`res_kind` = 3), regime 0 (kernel/user), VM selection 0 (current) and cause 0.
- R6: For an EXEC decision at level 1, `res_filt` is 1 (exclude XS) exactly when `xs_impl`, `xctl_impl` and `xctl_en` are all 1, `hyp_32` is 0 and `xs_excl` is 1. Otherwise it is 0 (all attributes).
- R7: A request at level 2 yields EXEC with regime 0, VM selection 0 and filter 0, whatever the trap bits and XS controls.
- R8: A request at level 3 yields EXEC with regime 1 (monitor), VM selection 1 (none) and filter 0.
- R9: The decision appears on the result ports on the clock edge after the edge that samples `req`. `res_vld` is high for exactly that one cycle. All result fields hold their values until the next request.
- R10: After reset, `res_vld` is 0, `res_kind` is UNDEF, and the syndrome, cause, regime, VM selection and filter are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled at the rising edge |
| lvl_in | input | 2 | Privilege level of the issuing context (0..3) |
| k32_ok | input | 1 | Level 1 is able to run 32-bit code |
| hyp_en | input | 1 | Hypervisor level is enabled |
| hyp_32 | input | 1 | Hypervisor runs in 32-bit state |
| grp_trap64 | input | 1 | Coprocessor-group trap bit, 64-bit hypervisor register |
| grp_trap32 | input | 1 | Coprocessor-group trap bit, 32-bit hypervisor register |
| tlb_trap64 | input | 1 | TLB maintenance trap bit, 64-bit register |
| tlbis_trap64 | input | 1 | Inner-shareable TLB maintenance trap bit, 64-bit register |
| tlb_trap32 | input | 1 | TLB maintenance trap bit, 32-bit register |
| tlbis_trap32 | input | 1 | Inner-shareable TLB maintenance trap bit, 32-bit register |
| xs_impl | input | 1 | XS attribute feature implemented |
| xctl_impl | input | 1 | Extended hypervisor control feature implemented |
| xctl_en | input | 1 | Extended hypervisor control register is enabled |
| xs_excl | input | 1 | Extended control bit asking to exclude XS entries |
| res_vld | output | 1 | One-cycle pulse: a new decision is on the result ports |
| res_kind | output | 2 | 0 UNDEF, 1 TRAP64, 2 TRAP32, 3 EXEC |
| res_synd | output | 6 | Syndrome code for a trap, else 0 |
| res_cause | output | 3 | Winning trap condition 1..6, else 0 |
| res_regime | output | 1 | 0 kernel/user regime, 1 monitor regime |
| res_vmsel | output | 1 | 0 current VM identifier, 1 none |
| res_filt | output | 1 | 0 all attributes, 1 exclude XS |

## Verification
On every cycle, assertions check several things. Level-0 and not-32-capable requests give UNDEF. Every trap carries syndrome 0x03 and a nonzero cause. Level-2 and level-3 requests give their fixed execute attributes. The result ports stay stable between requests, and the trap grant vector never has more than one bit set. The priority order among trap bits set together, the XS filter gating, the masking of trap bits when the hypervisor is disabled, and the reset values are shown only by the bench. It compares each decision against an independent model under directed and random mixes of controls.

// File: rtl/tlbi_judge_pkg.sv
package tlbi_judge_pkg;

    localparam int LVL_W   = 2;
    localparam int SYND_W  = 6;
    localparam int N_TRAP  = 6;
    localparam int CAUSE_W = $clog2(N_TRAP + 1);

    localparam logic [SYND_W-1:0] SYND_TRAP = 6'h03;

    // Route of each trap condition by priority index: 1 = 32-bit entry path
    localparam logic [N_TRAP-1:0] ROUTE32_MAP = 6'b110010;

    typedef enum logic [1:0] {
        K_UNDEF  = 2'd0,
        K_TRAP64 = 2'd1,
        K_TRAP32 = 2'd2,
        K_EXEC   = 2'd3
    } kind_e;

    typedef enum logic {
        RG_KERN = 1'b0,
        RG_MON  = 1'b1
    } regime_e;

    typedef enum logic {
        VM_CUR  = 1'b0,
        VM_NONE = 1'b1
    } vmsel_e;

    typedef enum logic {
        F_ALL  = 1'b0,
        F_NOXS = 1'b1
    } filt_e;

    typedef struct packed {
        kind_e                kind;
        logic [SYND_W-1:0]    synd;
        logic [CAUSE_W-1:0]   cause;
        regime_e              regime;
        vmsel_e               vmsel;
        filt_e                filt;
    } decision_t;

    localparam decision_t DEC_RESET = '{
        kind: K_UNDEF, synd: '0, cause: '0,
        regime: RG_KERN, vmsel: VM_CUR, filt: F_ALL
    };

    function automatic decision_t mk_undef();
        return DEC_RESET;
    endfunction

    function automatic decision_t mk_exec(regime_e rg, vmsel_e vm, filt_e f);
        decision_t d;
        d        = DEC_RESET;
        d.kind   = K_EXEC;
        d.regime = rg;
        d.vmsel  = vm;
        d.filt   = f;
        return d;
    endfunction

    function automatic decision_t mk_trap(logic r32, logic [CAUSE_W-1:0] c);
        decision_t d;
        d       = DEC_RESET;
        d.kind  = r32 ? K_TRAP32 : K_TRAP64;
        d.synd  = SYND_TRAP;
        d.cause = c;
        return d;
    endfunction

endpackage

// File: rtl/tlbi_trap_chain.sv
module tlbi_trap_chain
    import tlbi_judge_pkg::*;
#(
    parameter int                NT        = N_TRAP,
    parameter logic [NT-1:0]     ROUTE32   = ROUTE32_MAP,
    localparam int               CW        = $clog2(NT + 1)
) (
    input  logic          hyp_en,
    input  logic          hyp_32,
    input  logic [NT-1:0] ctl,
    output logic          hit,
    output logic          route32,
    output logic [CW-1:0] cause
);

    logic [NT-1:0] cond;
    logic [NT-1:0] grant;
    logic [NT:0]   seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NT; i++) begin : g_link
            // a condition is live only for the hypervisor state its register belongs to
            assign cond[i]    = hyp_en & ctl[i] & (ROUTE32[i] ? hyp_32 : ~hyp_32);
            assign grant[i]   = cond[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | cond[i];
        end
    endgenerate

    assign hit     = seen[NT];
    assign route32 = |(grant & ROUTE32);

    always_comb begin
        cause = '0;
        for (int i = 0; i < NT; i++) begin
            if (grant[i]) cause = CW'(i + 1);
        end
    end

    // R3
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
    end

endmodule

// File: rtl/tlbi_exec_attr.sv
module tlbi_exec_attr
    import tlbi_judge_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic [LW-1:0] lvl,
    input  logic          hyp_32,
    input  logic          xs_impl,
    input  logic          xctl_impl,
    input  logic          xctl_en,
    input  logic          xs_excl,
    output regime_e       regime,
    output vmsel_e        vmsel,
    output filt_e         filt
);

    localparam logic [LW-1:0] LVL_KERN = LW'(1);
    localparam logic [LW-1:0] LVL_MON  = LW'(3);

    logic noxs_ok;

    assign noxs_ok = xs_impl & xctl_impl & xctl_en & ~hyp_32 & xs_excl;

    always_comb begin
        regime = RG_KERN;
        vmsel  = VM_CUR;
        filt   = F_ALL;
        if (lvl == LVL_MON) begin
            regime = RG_MON;
            vmsel  = VM_NONE;
        end else if (lvl == LVL_KERN && noxs_ok) begin
            filt = F_NOXS;
        end
    end

endmodule

// File: rtl/tlbi_access_judge.sv
module tlbi_access_judge
    import tlbi_judge_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [LVL_W-1:0]   lvl_in,
    input  logic               k32_ok,
    input  logic               hyp_en,
    input  logic               hyp_32,
    input  logic               grp_trap64,
    input  logic               grp_trap32,
    input  logic               tlb_trap64,
    input  logic               tlbis_trap64,
    input  logic               tlb_trap32,
    input  logic               tlbis_trap32,
    input  logic               xs_impl,
    input  logic               xctl_impl,
    input  logic               xctl_en,
    input  logic               xs_excl,
    output logic               res_vld,
    output logic [1:0]         res_kind,
    output logic [SYND_W-1:0]  res_synd,
    output logic [CAUSE_W-1:0] res_cause,
    output logic               res_regime,
    output logic               res_vmsel,
    output logic               res_filt
);

    localparam logic [LVL_W-1:0] LVL_USR  = LVL_W'(0);
    localparam logic [LVL_W-1:0] LVL_KERN = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_HYP  = LVL_W'(2);
    localparam logic [LVL_W-1:0] LVL_MON  = LVL_W'(3);

    logic [N_TRAP-1:0]  ctl_vec;
    logic               trap_hit;
    logic               trap_r32;
    logic [CAUSE_W-1:0] trap_cause;
    regime_e            ex_regime;
    vmsel_e             ex_vmsel;
    filt_e              ex_filt;
    decision_t          dec_nxt;
    decision_t          dec_q;
    logic               vld_q;

    // priority order: index 0 is tried first
    assign ctl_vec = {tlbis_trap32, tlb_trap32, tlbis_trap64,
                      tlb_trap64, grp_trap32, grp_trap64};

    tlbi_trap_chain #(
        .NT      (N_TRAP),
        .ROUTE32 (ROUTE32_MAP)
    ) u_chain (
        .hyp_en  (hyp_en),
        .hyp_32  (hyp_32),
        .ctl     (ctl_vec),
        .hit     (trap_hit),
        .route32 (trap_r32),
        .cause   (trap_cause)
    );

    tlbi_exec_attr #(
        .LW (LVL_W)
    ) u_attr (
        .lvl       (lvl_in),
        .hyp_32    (hyp_32),
        .xs_impl   (xs_impl),
        .xctl_impl (xctl_impl),
        .xctl_en   (xctl_en),
        .xs_excl   (xs_excl),
        .regime    (ex_regime),
        .vmsel     (ex_vmsel),
        .filt      (ex_filt)
    );

    always_comb begin
        if (!k32_ok || lvl_in == LVL_USR) begin
            dec_nxt = mk_undef();
        end else if (lvl_in == LVL_KERN && trap_hit) begin
            dec_nxt = mk_trap(trap_r32, trap_cause);
        end else begin
            dec_nxt = mk_exec(ex_regime, ex_vmsel, ex_filt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= DEC_RESET;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req;
            if (req) dec_q <= dec_nxt;
        end
    end

    assign res_vld    = vld_q;
    assign res_kind   = dec_q.kind;
    assign res_synd   = dec_q.synd;
    assign res_cause  = dec_q.cause;
    assign res_regime = dec_q.regime;
    assign res_vmsel  = dec_q.vmsel;
    assign res_filt   = dec_q.filt;

    // R1
    usr_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (req && lvl_in == LVL_USR) |=> (res_kind == K_UNDEF && res_cause == '0));

    // R2
    narrow_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !k32_ok) |=> (res_kind == K_UNDEF && res_synd == '0));

    // R4
    trap_synd_chk: assert property (@(posedge clk) disable iff (rst)
        (res_kind == K_TRAP64 || res_kind == K_TRAP32) |->
            (res_synd == SYND_TRAP && res_cause != '0));

    // R7
    hyp_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (req && k32_ok && lvl_in == LVL_HYP) |=>
            (res_kind == K_EXEC && res_regime == RG_KERN &&
             res_vmsel == VM_CUR && res_filt == F_ALL));

    // R8
    mon_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (req && k32_ok && lvl_in == LVL_MON) |=>
            (res_kind == K_EXEC && res_regime == RG_MON &&
             res_vmsel == VM_NONE && res_filt == F_ALL));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!res_vld && $stable(res_kind) && $stable(res_synd) &&
                  $stable(res_cause) && $stable(res_regime) &&
                  $stable(res_vmsel) && $stable(res_filt)));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> res_vld);

endmodule

// File: tb/sim_tlbi_access_judge.sv
module sim_tlbi_access_judge;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;
    localparam int WDOG_LIM   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       req;
    logic [1:0] lvl_in;
    logic       k32_ok, hyp_en, hyp_32;
    logic       grp_trap64, grp_trap32, tlb_trap64, tlbis_trap64, tlb_trap32, tlbis_trap32;
    logic       xs_impl, xctl_impl, xctl_en, xs_excl;
    logic       res_vld;
    logic [1:0] res_kind;
    logic [5:0] res_synd;
    logic [2:0] res_cause;
    logic       res_regime, res_vmsel, res_filt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbi_access_judge u0 (
        .clk(clk), .rst(rst), .req(req), .lvl_in(lvl_in), .k32_ok(k32_ok),
        .hyp_en(hyp_en), .hyp_32(hyp_32),
        .grp_trap64(grp_trap64), .grp_trap32(grp_trap32),
        .tlb_trap64(tlb_trap64), .tlbis_trap64(tlbis_trap64),
        .tlb_trap32(tlb_trap32), .tlbis_trap32(tlbis_trap32),
        .xs_impl(xs_impl), .xctl_impl(xctl_impl), .xctl_en(xctl_en), .xs_excl(xs_excl),
        .res_vld(res_vld), .res_kind(res_kind), .res_synd(res_synd),
        .res_cause(res_cause), .res_regime(res_regime), .res_vmsel(res_vmsel),
        .res_filt(res_filt)
    );

    // expected {kind, synd, cause, regime, vmsel, filt} packed in 14 bits
    function automatic logic [13:0] model();
        logic [1:0] k; logic [5:0] s; logic [2:0] c; logic rg, vm, f;
        k = 2'd0; s = 6'd0; c = 3'd0; rg = 0; vm = 0; f = 0;
        if (!k32_ok || lvl_in == 2'd0) begin
            k = 2'd0;
        end else if (lvl_in == 2'd3) begin
            k = 2'd3; rg = 1; vm = 1;
        end else if (lvl_in == 2'd2) begin
            k = 2'd3;
        end else begin
            if      (hyp_en && !hyp_32 && grp_trap64)   begin k = 2'd1; c = 3'd1; end
            else if (hyp_en &&  hyp_32 && grp_trap32)   begin k = 2'd2; c = 3'd2; end
            else if (hyp_en && !hyp_32 && tlb_trap64)   begin k = 2'd1; c = 3'd3; end
            else if (hyp_en && !hyp_32 && tlbis_trap64) begin k = 2'd1; c = 3'd4; end
            else if (hyp_en &&  hyp_32 && tlb_trap32)   begin k = 2'd2; c = 3'd5; end
            else if (hyp_en &&  hyp_32 && tlbis_trap32) begin k = 2'd2; c = 3'd6; end
            else begin
                k = 2'd3;
                f = xs_impl && xctl_impl && xctl_en && !hyp_32 && xs_excl;
            end
            if (k == 2'd1 || k == 2'd2) s = 6'h03;
        end
        return {k, s, c, rg, vm, f};
    endfunction

    function automatic string tag_of();
        if (!k32_ok)          return "R2";
        if (lvl_in == 2'd0)   return "R1";
        if (lvl_in == 2'd2)   return "R7";
        if (lvl_in == 2'd3)   return "R8";
        if (!hyp_en)          return "R5";
        return "R3/R4/R6";
    endfunction

    task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] outs();
        return {res_kind, res_synd, res_cause, res_regime, res_vmsel, res_filt};
    endfunction

    task automatic set_ctl(logic [1:0] l, logic k, logic he, logic h32, logic [5:0] tb, logic [3:0] xs);
        lvl_in = l; k32_ok = k; hyp_en = he; hyp_32 = h32;
        {tlbis_trap32, tlb_trap32, tlbis_trap64, tlb_trap64, grp_trap32, grp_trap64} = tb;
        {xs_impl, xctl_impl, xctl_en, xs_excl} = xs;
    endtask

    // inputs already set at a falling edge; strobe for one cycle, check at next falling edge
    task automatic issue(string tag);
        logic [13:0] exp;
        exp = model();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(tag, outs(), exp);
        checks++;
        if (res_vld !== 1'b1) begin
            errors++;
            $display("FAIL R9 valid actual=%b expected=1", res_vld);
        end
    endtask

    task automatic dir(logic [1:0] l, logic k, logic he, logic h32, logic [5:0] tb, logic [3:0] xs, string tag);
        @(negedge clk);
        set_ctl(l, k, he, h32, tb, xs);
        issue(tag);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIM) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIM);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [13:0] held;
        void'($urandom(32'd20240611));
        rst = 1'b1; req = 1'b0;
        set_ctl(2'd1, 1, 1, 0, 6'h3f, 4'hf);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", {res_vld, outs()}, 15'd0);

        // R1 level 0 with every trap bit set
        dir(2'd0, 1, 1, 0, 6'h3f, 4'hf, "R1");
        // R2 not 32-capable at each level
        for (int l = 0; l < 4; l++) dir(2'(l), 0, 1, 0, 6'h3f, 4'hf, "R2");
        // R3 priority ladder, 64-bit hypervisor
        dir(2'd1, 1, 1, 0, 6'b111111, 4'h0, "R3");  // cause 1
        dir(2'd1, 1, 1, 0, 6'b111110, 4'h0, "R3");  // cause 3 (grp32 ignored)
        dir(2'd1, 1, 1, 0, 6'b111010, 4'h0, "R3");  // cause 4
        dir(2'd1, 1, 1, 0, 6'b110010, 4'h0, "R3");  // no 64-bit bit -> exec
        // R3 priority ladder, 32-bit hypervisor
        dir(2'd1, 1, 1, 1, 6'b111111, 4'h0, "R3");  // cause 2
        dir(2'd1, 1, 1, 1, 6'b111101, 4'h0, "R3");  // cause 5
        dir(2'd1, 1, 1, 1, 6'b101101, 4'h0, "R3");  // cause 6
        dir(2'd1, 1, 1, 1, 6'b001101, 4'h0, "R3");  // exec
        // R4 syndrome on both routes
        dir(2'd1, 1, 1, 0, 6'b000100, 4'h0, "R4");
        dir(2'd1, 1, 1, 1, 6'b010000, 4'h0, "R4");
        // R5 hypervisor disabled masks trap bits
        dir(2'd1, 1, 0, 0, 6'h3f, 4'h0, "R5");
        dir(2'd1, 1, 0, 1, 6'h3f, 4'h0, "R5");
        // R6 XS filter: all set, then each one cleared
        dir(2'd1, 1, 1, 0, 6'h0, 4'hf, "R6");
        for (int b = 0; b < 4; b++) dir(2'd1, 1, 1, 0, 6'h0, 4'hf & ~(4'h1 << b), "R6");
        dir(2'd1, 1, 1, 1, 6'h0, 4'hf, "R6");
        dir(2'd1, 1, 0, 0, 6'h0, 4'hf, "R6");
        // R7 / R8
        dir(2'd2, 1, 1, 0, 6'h3f, 4'hf, "R7");
        dir(2'd3, 1, 1, 1, 6'h3f, 4'hf, "R8");

        // R9 hold: change inputs with no strobe, result must stay
        held = outs();
        @(negedge clk);
        set_ctl(2'd1, 1, 1, 0, 6'h01, 4'h0);
        repeat (3) @(negedge clk);
        check("R9", {res_vld, outs()}, {1'b0, held});

        // random mix
        for (int n = 0; n < N_RAND; n++) begin
            @(negedge clk);
            set_ctl(2'($urandom_range(0, 3)), ($urandom_range(0, 7) != 0),
                    1'($urandom), 1'($urandom),
                    6'($urandom) & 6'($urandom), 4'($urandom) | 4'($urandom));
            issue(tag_of());
            if ($urandom_range(0, 3) == 0) begin
                held = outs();
                @(negedge clk);
                check("R9", {res_vld, outs()}, {1'b0, held});
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule